// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the serial side of a flash memory. It is a mode-0 SPI target that is clocked by a system clock `clk`, which must be fast compared with the controller's `sclk`. While `cs_n` is low it takes in an opcode and any address bytes on `mosi`. After that it either drives `miso` with a response or goes quiet until the next select. It serves three read-type commands: a streaming array read, an identifier read and a continuous status read. An opcode it does not recognise sends it into standby.

Array bytes come through a small request/response port. A request is offered with `mem_req_valid` and `mem_addr`, and it is accepted in a cycle where `mem_req_ready` is high. The memory may stall by holding `mem_req_ready` low for any number of cycles, and the block then keeps its request unchanged. Data returns on `mem_rsp_valid`/`mem_rsp_data` after any latency. Only one request is ever outstanding, so no response back-pressure exists. The block reads one byte ahead of the serial stream. Each request therefore has to complete within one serial byte time (8 `sclk` periods), or the stream repeats stale data. The status byte arrives on a plain input from a separate status block.

The bench's memory and status block sit outside. Program/erase execution and array timing are not part of this block. `sclk` must stay low for at least 4 `clk` cycles and high for at least 4 `clk` cycles.

Top module: `sflash_cmd_front`

## Requirements
- R1: While `cs_n` is high, `miso_oe` is 0 and, from the second such cycle on, `mem_req_valid` is 0. After reset with `cs_n` high, both are 0.
- R2: Opcode 0xE8 starts an array read. It is followed by 3 address bytes, most significant byte first, of which only the low log2(ARRAY_BYTES) bits are used. Then come 4 dummy bytes. The first data byte is the array byte at that address, sent MSB first.
- R3: `mosi` is sampled on rising `sclk` and `miso` changes only on falling `sclk`. Each further group of 8 clocks in an array read carries the byte at the next address.
- R4: After the byte at address ARRAY_BYTES-1, an array read continues at address 0.
- R5: Opcode 0x9F, followed by one dummy byte, returns 0xC2 and then 0x9C. The pair then repeats for as long as clocks continue.
- R6: Opcode 0xD7 streams `status_byte` MSB first, starting with the first clock after the opcode. The input is sampled again at each byte boundary and is repeated indefinitely.
- R7: Any other opcode puts the block in standby. `miso_oe` stays 0, no memory request is made, and all further `mosi` bytes (even valid opcodes) are ignored until `cs_n` rises.
- R8: A rise of `cs_n` ends any command at once, `miso_oe` drops in the same cycle, and the next select decodes a fresh opcode.
- R9: `mem_req_valid`, once high, stays high with `mem_addr` unchanged until `mem_req_ready` is seen, unless `cs_n` is high. Stalls of the memory do not corrupt the stream.
- R10: `miso_oe` is 0 throughout the opcode, address and dummy bytes of any command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the controller, idles low |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Output enable for `miso`; 0 means high-impedance |
| status_byte | input | 8 | Current status register from the status block |
| mem_req_valid | output | 1 | Array read request offered |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_addr | output | AW | Byte address of the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Read data byte |

## Verification
Array reads are tried at a low address with an always-ready memory and at an address whose top header bit must be discarded with a memory that accepts only one cycle in eight. The first shows the address ordering and the byte advance. The second shows that requests are held correctly and that address truncation is right. A read that starts two bytes below the array end separates a wrap to zero from a run-off into unmapped space. Identifier and status streams with changing status values show the code order and the per-byte resampling. An unknown opcode followed by valid-looking bytes, and a select pulled high in mid-byte, show that standby ignores input and that an abort leaves no trace on the next command.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  // command phase of the front-end
  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_DUMMY,
    PH_IDDUM,
    PH_ARRAY,
    PH_IDENT,
    PH_STAT,
    PH_STBY
  } phase_e;

  // array fetch engine state
  typedef enum logic [1:0] {
    FT_IDLE,
    FT_REQ,
    FT_WAIT
  } fetch_e;

endpackage

// File: rtl/sfc_edge.sv
module sfc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/sfc_rx.sv
module sfc_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         rise,
  input  logic         mosi,
  output logic         rx_valid,
  output logic [W-1:0] rx_byte
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (clear) begin
        sh_q  <= '0;
        cnt_q <= '0;
      end else if (rise) begin
        sh_q  <= {sh_q[W-2:0], mosi};
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          rx_valid <= 1'b1;
          rx_byte  <= {sh_q[W-2:0], mosi};
        end
      end
    end
  end
endmodule

// File: rtl/sfc_tx.sv
module sfc_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         en,
  input  logic         fall,
  input  logic [W-1:0] next_byte,
  output logic         miso,
  output logic         load
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;

  // a new byte is taken on the first falling edge of each byte slot
  assign load = en & fall & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      miso  <= 1'b0;
    end else if (clear) begin
      sh_q  <= '0;
      cnt_q <= '0;
      miso  <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
    end else if (fall) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      if (cnt_q == '0) begin
        miso <= next_byte[W-1];
        sh_q <= {next_byte[W-2:0], 1'b0};
      end else begin
        miso <= sh_q[W-1];
        sh_q <= {sh_q[W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/sfc_fetch.sv
module sfc_fetch
  import sfc_pkg::*;
#(
  parameter int ARRAY_BYTES = 1 << 23,
  parameter int AW          = $clog2(ARRAY_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          take,
  output logic [7:0]    buf_byte,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rsp_valid,
  input  logic [7:0]    mem_rsp_data
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(ARRAY_BYTES - 1);

  fetch_e        st_q;
  logic [AW-1:0] addr_q;
  logic          buf_vld_q, drop_q, active_q;

  assign mem_req_valid = (st_q == FT_REQ);
  assign mem_addr      = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= FT_IDLE;
      addr_q    <= '0;
      buf_byte  <= '0;
      buf_vld_q <= 1'b0;
      drop_q    <= 1'b0;
      active_q  <= 1'b0;
    end else begin
      if (clear) begin
        active_q  <= 1'b0;
        buf_vld_q <= 1'b0;
      end else if (start) begin
        active_q  <= 1'b1;
        addr_q    <= start_addr;
        buf_vld_q <= 1'b0;
      end else if (take) begin
        buf_vld_q <= 1'b0;
      end

      unique case (st_q)
        FT_IDLE: if (active_q && !buf_vld_q && !clear && !start) st_q <= FT_REQ;
        FT_REQ: begin
          if (clear)              st_q <= FT_IDLE;
          else if (mem_req_ready) st_q <= FT_WAIT;
        end
        FT_WAIT: begin
          if (mem_rsp_valid) begin
            st_q   <= FT_IDLE;
            drop_q <= 1'b0;
            if (!drop_q && !clear) begin
              buf_byte  <= mem_rsp_data;
              buf_vld_q <= 1'b1;
              addr_q    <= (addr_q == LAST_ADDR) ? '0 : addr_q + 1'b1;
            end
          end else if (clear) begin
            drop_q <= 1'b1;
          end
        end
        default: st_q <= FT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sflash_cmd_front.sv
module sflash_cmd_front
  import sfc_pkg::*;
#(
  parameter int         ARRAY_BYTES = 1 << 23,
  parameter int         ADDR_BYTES  = 3,
  parameter int         DUMMY_BYTES = 4,
  parameter logic [7:0] OP_READ     = 8'hE8,
  parameter logic [7:0] OP_IDENT    = 8'h9F,
  parameter logic [7:0] OP_STATUS   = 8'hD7,
  parameter logic [7:0] MFR_CODE    = 8'hC2,
  parameter logic [7:0] DEV_CODE    = 8'h9C,
  localparam int        AW          = $clog2(ARRAY_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  input  logic [7:0]    status_byte,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rsp_valid,
  input  logic [7:0]    mem_rsp_data
);
  localparam int MAXB = (DUMMY_BYTES > ADDR_BYTES) ? DUMMY_BYTES : ADDR_BYTES;
  localparam int CNTW = $clog2(MAXB) + 1;
  localparam logic [CNTW-1:0] ADDR_LAST  = CNTW'(ADDR_BYTES - 1);
  localparam logic [CNTW-1:0] DUMMY_LAST = CNTW'(DUMMY_BYTES - 1);

  logic          rise, fall, rx_valid, load, data_mode, start, take, id_sel_q;
  logic [7:0]    rx_byte, buf_byte, next_byte;
  logic [AW-1:0] hdr_q, hdr_next;
  logic [CNTW-1:0] cnt_q;
  phase_e        ph_q;

  sfc_edge u_edge (.clk(clk), .rst_n(rst_n), .sclk(sclk), .rise(rise), .fall(fall));

  sfc_rx #(.W(8)) u_rx (
    .clk(clk), .rst_n(rst_n), .clear(cs_n), .rise(rise), .mosi(mosi),
    .rx_valid(rx_valid), .rx_byte(rx_byte)
  );

  assign hdr_next = {hdr_q[AW-9:0], rx_byte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_OPC;
      cnt_q    <= '0;
      hdr_q    <= '0;
      id_sel_q <= 1'b0;
    end else if (cs_n) begin
      ph_q     <= PH_OPC;
      cnt_q    <= '0;
      id_sel_q <= 1'b0;
    end else begin
      if (load && ph_q == PH_IDENT) id_sel_q <= ~id_sel_q;
      if (rx_valid) begin
        unique case (ph_q)
          PH_OPC: begin
            cnt_q <= '0;
            if (rx_byte == OP_READ)        ph_q <= PH_ADDR;
            else if (rx_byte == OP_IDENT)  ph_q <= PH_IDDUM;
            else if (rx_byte == OP_STATUS) ph_q <= PH_STAT;
            else                           ph_q <= PH_STBY;
          end
          PH_ADDR: begin
            hdr_q <= hdr_next;
            if (cnt_q == ADDR_LAST) begin
              ph_q  <= PH_DUMMY;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_DUMMY: begin
            if (cnt_q == DUMMY_LAST) ph_q <= PH_ARRAY;
            else                     cnt_q <= cnt_q + 1'b1;
          end
          PH_IDDUM: ph_q <= PH_IDENT;
          default: ;
        endcase
      end
    end
  end

  assign start     = rx_valid & ~cs_n & (ph_q == PH_ADDR) & (cnt_q == ADDR_LAST);
  assign data_mode = (ph_q == PH_ARRAY) | (ph_q == PH_IDENT) | (ph_q == PH_STAT);
  assign take      = load & (ph_q == PH_ARRAY);
  assign miso_oe   = data_mode & ~cs_n;

  always_comb begin
    unique case (ph_q)
      PH_ARRAY: next_byte = buf_byte;
      PH_IDENT: next_byte = id_sel_q ? DEV_CODE : MFR_CODE;
      PH_STAT:  next_byte = status_byte;
      default:  next_byte = 8'h00;
    endcase
  end

  sfc_fetch #(.ARRAY_BYTES(ARRAY_BYTES), .AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .clear(cs_n), .start(start), .start_addr(hdr_next),
    .take(take), .buf_byte(buf_byte),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  sfc_tx #(.W(8)) u_tx (
    .clk(clk), .rst_n(rst_n), .clear(cs_n), .en(data_mode), .fall(fall),
    .next_byte(next_byte), .miso(miso), .load(load)
  );
endmodule

// File: rtl/sfc_chk.sv
module sfc_chk #(
  parameter int AW = 23
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sclk,
  input logic          miso,
  input logic          miso_oe,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_addr
);
  // R1
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !miso_oe);

  // R1
  no_req_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n) && cs_n) |-> !mem_req_valid);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !cs_n) |=> (mem_req_valid && $stable(mem_addr)));

  // R3
  miso_high_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n) && sclk && $past(sclk)) |-> $stable(miso));
endmodule

bind sflash_cmd_front sfc_chk #(.AW(AW)) u_sfc_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .miso(miso), .miso_oe(miso_oe),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr)
);

// File: tb/tb_sflash_cmd_front.sv
module tb_sflash_cmd_front;
  localparam int AW = 23;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, miso_oe, mem_req_valid, mem_rsp_valid = 1'b0, mem_req_ready = 1'b1;
  logic [7:0] status_byte = 8'h00, mem_rsp_data = 8'h00;
  logic [AW-1:0] mem_addr;
  logic stall_mode = 1'b0;
  logic [2:0] stall_cnt = '0;
  int req_count = 0, total = 0, bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  sflash_cmd_front dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .status_byte(status_byte),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {1'b0, a[22:16]} ^ 8'h3C;
  endfunction

  // behavioural array memory, one-cycle response, optional accept stalls
  always @(posedge clk) begin
    stall_cnt     <= stall_cnt + 3'd1;
    mem_req_ready <= stall_mode ? (stall_cnt == 3'd5) : 1'b1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= pat(mem_addr);
      req_count     <= req_count + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all, output logic oe_any);
    oe_all = 1'b1;
    oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sclk = 1'b0; mosi = tx[i];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      #1;
      rx[i]  = miso;
      oe_all = oe_all & miso_oe;
      oe_any = oe_any | miso_oe;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic cs_begin();
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_end();
    @(negedge clk); sclk = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    check(miso_oe == 1'b0, "R1 oe after reset", miso_oe, 0);
    check(mem_req_valid == 1'b0, "R1 no request after reset", mem_req_valid, 0);
  endtask

  task automatic t_read(input logic [23:0] a, input int n, input bit stall, input string tag);
    logic [7:0] rx;
    logic oa, on, hdr_oe;
    logic [AW-1:0] eff;
    stall_mode = stall;
    hdr_oe = 1'b0;
    eff = a[AW-1:0];
    cs_begin();
    xfer(8'hE8, rx, oa, on); hdr_oe |= on;
    xfer(a[23:16], rx, oa, on); hdr_oe |= on;
    xfer(a[15:8], rx, oa, on); hdr_oe |= on;
    xfer(a[7:0], rx, oa, on); hdr_oe |= on;
    for (int d = 0; d < 4; d++) begin
      xfer(8'h00, rx, oa, on); hdr_oe |= on;
    end
    check(hdr_oe == 1'b0, {"R10 oe during header ", tag}, hdr_oe, 0);
    for (int k = 0; k < n; k++) begin
      logic [AW-1:0] ea;
      ea = eff + AW'(k);  // modulo 2^AW wrap
      xfer(8'h00, rx, oa, on);
      check(oa == 1'b1, {"R2 oe in data ", tag}, oa, 1);
      check(rx == pat(ea), {"R3 R4 R9 array byte ", tag}, rx, pat(ea));
    end
    cs_end();
    check(miso_oe == 1'b0, {"R1 oe after deselect ", tag}, miso_oe, 0);
    stall_mode = 1'b0;
  endtask

  task automatic t_ident();
    logic [7:0] rx;
    logic oa, on, hdr_oe;
    cs_begin();
    xfer(8'h9F, rx, oa, on); hdr_oe = on;
    xfer(8'h00, rx, oa, on); hdr_oe |= on;
    check(hdr_oe == 1'b0, "R10 oe during ident header", hdr_oe, 0);
    for (int k = 0; k < 4; k++) begin
      xfer(8'h00, rx, oa, on);
      check(oa == 1'b1, "R5 oe during ident", oa, 1);
      check(rx == ((k % 2 == 0) ? 8'hC2 : 8'h9C), "R5 ident byte", rx, (k % 2 == 0) ? 8'hC2 : 8'h9C);
    end
    cs_end();
  endtask

  task automatic t_status();
    logic [7:0] rx;
    logic oa, on;
    logic [7:0] vals [4];
    vals[0] = 8'hA5; vals[1] = 8'h3C; vals[2] = 8'h81; vals[3] = 8'h81;
    cs_begin();
    xfer(8'hD7, rx, oa, on);
    check(on == 1'b0, "R10 oe during status opcode", on, 0);
    for (int k = 0; k < 4; k++) begin
      status_byte = vals[k];
      xfer(8'h00, rx, oa, on);
      check(oa == 1'b1, "R6 oe during status", oa, 1);
      check(rx == vals[k], "R6 status byte", rx, vals[k]);
    end
    cs_end();
  endtask

  task automatic t_standby();
    logic [7:0] rx;
    logic oa, on, any;
    int rc0;
    rc0 = req_count;
    any = 1'b0;
    cs_begin();
    xfer(8'h55, rx, oa, on); any |= on;
    xfer(8'h9F, rx, oa, on); any |= on;
    xfer(8'h00, rx, oa, on); any |= on;
    xfer(8'hE8, rx, oa, on); any |= on;
    for (int k = 0; k < 7; k++) begin
      xfer(8'h00, rx, oa, on); any |= on;
    end
    check(any == 1'b0, "R7 oe stays low in standby", any, 0);
    check(req_count == rc0, "R7 no memory request in standby", req_count, rc0);
    cs_end();
  endtask

  task automatic t_abort();
    logic [7:0] rx;
    logic oa, on;
    cs_begin();
    xfer(8'hE8, rx, oa, on);
    xfer(8'h00, rx, oa, on);
    xfer(8'h01, rx, oa, on);
    xfer(8'h00, rx, oa, on);
    for (int d = 0; d < 4; d++) xfer(8'h00, rx, oa, on);
    xfer(8'h00, rx, oa, on);
    check(rx == pat(23'h000100), "R2 first byte before abort", rx, pat(23'h000100));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); sclk = 1'b0;
      repeat (4) @(negedge clk); sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    check(miso_oe == 1'b1, "R8 oe before abort", miso_oe, 1);
    cs_n = 1'b1;
    #1;
    check(miso_oe == 1'b0, "R8 oe drops with cs_n", miso_oe, 0);
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_read(24'h001234, 6, 1'b0, "low");
    t_read(24'hBF00A0, 4, 1'b1, "stalled");
    t_read(24'h7FFFFE, 4, 1'b0, "wrap");
    t_ident();
    t_status();
    t_standby();
    t_ident();   // R7: standby ends at deselect
    t_abort();
    t_ident();   // R8: fresh decode after abort
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule